// File: doc/BRIEF.md
# Intra-Word Register Renamer

This block renames register operands while a wide execution word is being assembled from individual microoperations. Each architectural register has a small entry that remembers whether some earlier microoperation in the current word has written it, which slot produced it, and whether the word has already read its incoming value. An incoming microoperation presents two source operands, an optional destination register and the slot it will occupy. In the same cycle the block rewrites each register source: if a producer exists inside the word, the source becomes a reference to that slot; otherwise it stays a plain register reference and the read is noted.

The table is updated on the clock edge after the lookup. A new-word strobe empties the table; the microoperation presented together with that strobe is the first member of the new word. The write mask and the per-register producer slots are visible continuously, so that when the word is closed the surrounding logic can copy exactly the written registers, each with its final producer, into the main rename table.

Top module: `wordrat`

## Requirements
- R1: After reset every write-valid and read-valid bit is zero (`wr_mask_o` and `rd_mask_o` all zero).
- R2: A cycle with `start_i` high clears all write-valid and read-valid bits; a microoperation presented in that same cycle is translated against an empty table and its own updates are kept.
- R3: Operand kind codes are 0 = constant, 1 = register, 2 = slot reference, 3 = reserved. Any source whose kind is not 1 leaves the block with the same kind and the same value.
- R4: A register source (kind 1, register number in the low `REG_W` bits of the value) whose write-valid bit is set leaves as kind 2 with the value equal to that register's producer slot, zero-extended.
- R5: A register source whose write-valid bit is clear leaves unchanged as kind 1; the register's read-valid bit becomes set and, if it was not already set in this word, its read slot becomes the reader's slot (the first reader is kept).
- R6: A valid microoperation with `dst_en_i` high sets the write-valid bit of `dst_reg_i` and stores `uop_slot_i` as its producer slot.
- R7: Both sources are looked up before the microoperation's own destination write takes effect, so a microoperation that reads and writes the same register sees the state from before it.
- R8: A later write to a register already written in the same word replaces its producer slot; the last writer is reported.
- R9: Register i's write-valid and read-valid bits are at bit i of `wr_mask_o` and `rd_mask_o`; its producer and first-reader slots are at bits [i*SLOT_W +: SLOT_W] of `wr_slot_o` and `rd_slot_o`, meaningful only where the matching mask bit is set. Without `start_i` no mask bit ever falls.
- R10: While `uop_valid_i` and `start_i` are both low, no table state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new word: clear all valid bits |
| uop_valid_i | input | 1 | A microoperation is presented this cycle |
| uop_slot_i | input | SLOT_W | Slot the microoperation occupies in the word |
| src_a_kind_i | input | 2 | Kind code of source A |
| src_a_val_i | input | VAL_W | Constant, register number or slot of source A |
| src_b_kind_i | input | 2 | Kind code of source B |
| src_b_val_i | input | VAL_W | Constant, register number or slot of source B |
| dst_en_i | input | 1 | Microoperation writes a register |
| dst_reg_i | input | REG_W | Destination register number |
| src_a_kind_o | output | 2 | Translated kind of source A |
| src_a_val_o | output | VAL_W | Translated value of source A |
| src_b_kind_o | output | 2 | Translated kind of source B |
| src_b_val_o | output | VAL_W | Translated value of source B |
| wr_mask_o | output | NUM_REGS | Write-valid bit per register |
| wr_slot_o | output | NUM_REGS*SLOT_W | Producer slot per register |
| rd_mask_o | output | NUM_REGS | Read-valid bit per register |
| rd_slot_o | output | NUM_REGS*SLOT_W | First-reader slot per register |

## Verification
The hardest case to reach is a new-word strobe arriving together with a microoperation whose sources name registers that the closing word had written: the lookup must already see an empty table while the same edge both clears and re-fills entries. The directed sequence builds a word with forwarded registers and then issues exactly that combination, and the random phase inserts new-word strobes at arbitrary points with dense register reuse over a few registers, so same-register read-and-write and repeated writers occur often.

// File: rtl/wordrat_pkg.sv
package wordrat_pkg;
   typedef enum logic [1:0] {
      OPK_CONST = 2'd0,
      OPK_REG   = 2'd1,
      OPK_SLOT  = 2'd2,
      OPK_RSVD  = 2'd3
   } opnd_kind_e;
endpackage

// File: rtl/wordrat_entry.sv
module wordrat_entry #(
   parameter int SLOT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              wr_hit_i,
   input  logic              rd_hit_i,
   input  logic [SLOT_W-1:0] slot_i,
   output logic              wv_o,
   output logic [SLOT_W-1:0] wa_o,
   output logic              rv_o,
   output logic [SLOT_W-1:0] ra_o
);
   logic rv_live;
   assign rv_live = rv_o && !clear_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wv_o <= 1'b0;
         wa_o <= '0;
         rv_o <= 1'b0;
         ra_o <= '0;
      end else begin
         if (clear_i) begin
            wv_o <= 1'b0;
            rv_o <= 1'b0;
         end
         if (wr_hit_i) begin
            wv_o <= 1'b1;
            wa_o <= slot_i;
         end
         if (rd_hit_i && !rv_live) begin
            rv_o <= 1'b1;
            ra_o <= slot_i;
         end
      end
   end
endmodule

// File: rtl/wordrat_xlate.sv
module wordrat_xlate #(
   parameter int NUM_REGS = 16,
   parameter int SLOT_W   = 2,
   parameter int VAL_W    = 8,
   parameter int REG_W    = 4
) (
   input  logic [1:0]               kind_i,
   input  logic [VAL_W-1:0]         val_i,
   input  logic [NUM_REGS-1:0]      wv_view_i,
   input  logic [NUM_REGS*SLOT_W-1:0] wa_i,
   output logic [1:0]               kind_o,
   output logic [VAL_W-1:0]         val_o,
   output logic                     rd_req_o,
   output logic [REG_W-1:0]         rd_idx_o
);
   import wordrat_pkg::*;

   always_comb begin
      rd_idx_o = val_i[REG_W-1:0];
      kind_o   = kind_i;
      val_o    = val_i;
      rd_req_o = 1'b0;
      if (kind_i == OPK_REG) begin
         if (wv_view_i[rd_idx_o]) begin
            kind_o = OPK_SLOT;
            val_o  = VAL_W'(wa_i[rd_idx_o*SLOT_W +: SLOT_W]);
         end else begin
            rd_req_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/wordrat.sv
module wordrat #(
   parameter int NUM_REGS  = 16,
   parameter int NUM_SLOTS = 4,
   parameter int VAL_W     = 8,
   localparam int REG_W    = $clog2(NUM_REGS),
   localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic                       uop_valid_i,
   input  logic [SLOT_W-1:0]          uop_slot_i,
   input  logic [1:0]                 src_a_kind_i,
   input  logic [VAL_W-1:0]           src_a_val_i,
   input  logic [1:0]                 src_b_kind_i,
   input  logic [VAL_W-1:0]           src_b_val_i,
   input  logic                       dst_en_i,
   input  logic [REG_W-1:0]           dst_reg_i,
   output logic [1:0]                 src_a_kind_o,
   output logic [VAL_W-1:0]           src_a_val_o,
   output logic [1:0]                 src_b_kind_o,
   output logic [VAL_W-1:0]           src_b_val_o,
   output logic [NUM_REGS-1:0]        wr_mask_o,
   output logic [NUM_REGS*SLOT_W-1:0] wr_slot_o,
   output logic [NUM_REGS-1:0]        rd_mask_o,
   output logic [NUM_REGS*SLOT_W-1:0] rd_slot_o
);
   generate
      if (NUM_REGS < 2 || NUM_REGS != (1 << REG_W)) begin : g_bad_regs
         $error("wordrat: NUM_REGS must be a power of two, at least 2");
      end
      if (VAL_W < REG_W || VAL_W < SLOT_W) begin : g_bad_val
         $error("wordrat: VAL_W too narrow for a register or slot number");
      end
   endgenerate

   logic [NUM_REGS-1:0] wv_view;
   logic                rd_a_req, rd_b_req;
   logic [REG_W-1:0]    rd_a_idx, rd_b_idx;

   assign wv_view = start_i ? '0 : wr_mask_o;

   wordrat_xlate #(
      .NUM_REGS(NUM_REGS), .SLOT_W(SLOT_W), .VAL_W(VAL_W), .REG_W(REG_W)
   ) xlate_a_i (
      .kind_i(src_a_kind_i), .val_i(src_a_val_i),
      .wv_view_i(wv_view), .wa_i(wr_slot_o),
      .kind_o(src_a_kind_o), .val_o(src_a_val_o),
      .rd_req_o(rd_a_req), .rd_idx_o(rd_a_idx)
   );

   wordrat_xlate #(
      .NUM_REGS(NUM_REGS), .SLOT_W(SLOT_W), .VAL_W(VAL_W), .REG_W(REG_W)
   ) xlate_b_i (
      .kind_i(src_b_kind_i), .val_i(src_b_val_i),
      .wv_view_i(wv_view), .wa_i(wr_slot_o),
      .kind_o(src_b_kind_o), .val_o(src_b_val_o),
      .rd_req_o(rd_b_req), .rd_idx_o(rd_b_idx)
   );

   generate
      for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_ent
         logic wr_hit, rd_hit;
         assign wr_hit = uop_valid_i && dst_en_i && (dst_reg_i == REG_W'(gi));
         assign rd_hit = uop_valid_i &&
                         ((rd_a_req && (rd_a_idx == REG_W'(gi))) ||
                          (rd_b_req && (rd_b_idx == REG_W'(gi))));
         wordrat_entry #(.SLOT_W(SLOT_W)) ent_i (
            .clk(clk), .rst_n(rst_n), .clear_i(start_i),
            .wr_hit_i(wr_hit), .rd_hit_i(rd_hit), .slot_i(uop_slot_i),
            .wv_o(wr_mask_o[gi]), .wa_o(wr_slot_o[gi*SLOT_W +: SLOT_W]),
            .rv_o(rd_mask_o[gi]), .ra_o(rd_slot_o[gi*SLOT_W +: SLOT_W])
         );
      end
   endgenerate
endmodule

// File: rtl/wordrat_checker.sv
module wordrat_checker #(
   parameter int NUM_REGS  = 16,
   parameter int NUM_SLOTS = 4,
   parameter int VAL_W     = 8,
   localparam int REG_W    = $clog2(NUM_REGS),
   localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       start_i,
   input logic                       uop_valid_i,
   input logic [SLOT_W-1:0]          uop_slot_i,
   input logic [1:0]                 src_a_kind_i,
   input logic [VAL_W-1:0]           src_a_val_i,
   input logic [1:0]                 src_b_kind_i,
   input logic [VAL_W-1:0]           src_b_val_i,
   input logic                       dst_en_i,
   input logic [REG_W-1:0]           dst_reg_i,
   input logic [1:0]                 src_a_kind_o,
   input logic [VAL_W-1:0]           src_a_val_o,
   input logic [1:0]                 src_b_kind_o,
   input logic [VAL_W-1:0]           src_b_val_o,
   input logic [NUM_REGS-1:0]        wr_mask_o,
   input logic [NUM_REGS*SLOT_W-1:0] wr_slot_o,
   input logic [NUM_REGS-1:0]        rd_mask_o,
   input logic [NUM_REGS*SLOT_W-1:0] rd_slot_o
);
   logic [REG_W-1:0]  a_idx, b_idx;
   logic              wr_fire_q;
   logic [REG_W-1:0]  wr_reg_q;
   logic [SLOT_W-1:0] wr_slot_q;

   assign a_idx = src_a_val_i[REG_W-1:0];
   assign b_idx = src_b_val_i[REG_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_fire_q <= 1'b0;
         wr_reg_q  <= '0;
         wr_slot_q <= '0;
      end else begin
         wr_fire_q <= uop_valid_i && dst_en_i;
         wr_reg_q  <= dst_reg_i;
         wr_slot_q <= uop_slot_i;
      end
   end

   // R2: a bare new-word strobe empties the table
   a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !uop_valid_i) |=> (wr_mask_o == '0 && rd_mask_o == '0));

   // R3: non-register operands pass through
   a_r3_passthru_a: assert property (@(posedge clk) disable iff (!rst_n)
      (src_a_kind_i != 2'd1) |-> (src_a_kind_o == src_a_kind_i && src_a_val_o == src_a_val_i));
   a_r3_passthru_b: assert property (@(posedge clk) disable iff (!rst_n)
      (src_b_kind_i != 2'd1) |-> (src_b_kind_o == src_b_kind_i && src_b_val_o == src_b_val_i));

   // R4: written register is forwarded from its producer slot
   a_r4_forward_a: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && src_a_kind_i == 2'd1 && wr_mask_o[a_idx]) |->
      (src_a_kind_o == 2'd2 && src_a_val_o == VAL_W'(wr_slot_o[a_idx*SLOT_W +: SLOT_W])));

   // R5: unwritten register read is recorded
   a_r5_read_noted: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid_i && !start_i && src_b_kind_i == 2'd1 && !wr_mask_o[b_idx]) |=>
      rd_mask_o[$past(b_idx)]);

   // R6 / R8: last write lands in the entry
   a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire_q |-> (wr_mask_o[wr_reg_q] && wr_slot_o[wr_reg_q*SLOT_W +: SLOT_W] == wr_slot_q));

   // R9: masks never fall without a new word
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> (((wr_mask_o & $past(wr_mask_o)) == $past(wr_mask_o)) &&
                    ((rd_mask_o & $past(rd_mask_o)) == $past(rd_mask_o))));

   // R10: idle cycles leave the table alone
   a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!uop_valid_i && !start_i) |=> ($stable(wr_mask_o) && $stable(rd_mask_o) &&
                                       $stable(wr_slot_o) && $stable(rd_slot_o)));
endmodule

bind wordrat wordrat_checker #(
   .NUM_REGS(NUM_REGS), .NUM_SLOTS(NUM_SLOTS), .VAL_W(VAL_W)
) chk_i (.*);

// File: tb/wordrat_tb_top.sv
`timescale 1ns/1ps
module wordrat_tb_top;
   localparam int NR = 16;
   localparam int SW = 2;
   localparam int VW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0, uop_valid_i = 1'b0, dst_en_i = 1'b0;
   logic [SW-1:0] uop_slot_i = '0;
   logic [1:0]    src_a_kind_i = '0, src_b_kind_i = '0;
   logic [VW-1:0] src_a_val_i = '0, src_b_val_i = '0;
   logic [3:0]    dst_reg_i = '0;
   logic [1:0]    src_a_kind_o, src_b_kind_o;
   logic [VW-1:0] src_a_val_o, src_b_val_o;
   logic [NR-1:0] wr_mask_o, rd_mask_o;
   logic [NR*SW-1:0] wr_slot_o, rd_slot_o;

   int checks = 0;
   int fails  = 0;

   bit m_wv[NR];
   int m_wa[NR];
   bit m_rv[NR];
   int m_ra[NR];

   always #4 clk = ~clk;

   wordrat #(.NUM_REGS(NR), .NUM_SLOTS(4), .VAL_W(VW)) dut_i (.*);

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic check_state(string tag);
      for (int i = 0; i < NR; i++) begin
         chk(tag, $sformatf("wr_mask[%0d]", i), int'(wr_mask_o[i]), int'(m_wv[i]));
         chk(tag, $sformatf("rd_mask[%0d]", i), int'(rd_mask_o[i]), int'(m_rv[i]));
         if (m_wv[i]) chk(tag, $sformatf("wr_slot[%0d]", i), int'(wr_slot_o[i*SW +: SW]), m_wa[i]);
         if (m_rv[i]) chk(tag, $sformatf("rd_slot[%0d]", i), int'(rd_slot_o[i*SW +: SW]), m_ra[i]);
      end
   endtask

   // expected translation of one source: kind, value, and whether it is a read to note
   task automatic expect_src(input bit st, input int k, input int v,
                             output int ek, output int ev, output bit note);
      int idx = v % NR;
      ek = k; ev = v; note = 0;
      if (k == 1) begin
         if (!st && m_wv[idx]) begin ek = 2; ev = m_wa[idx]; end
         else note = 1;
      end
   endtask

   task automatic step(string tag, bit st, bit v, int slot, int ak, int av,
                       int bk, int bv, bit de, int dr);
      int eak, eav, ebk, ebv;
      bit na, nb;
      @(negedge clk);
      check_state(tag);
      start_i = st; uop_valid_i = v; uop_slot_i = SW'(slot);
      src_a_kind_i = 2'(ak); src_a_val_i = VW'(av);
      src_b_kind_i = 2'(bk); src_b_val_i = VW'(bv);
      dst_en_i = de; dst_reg_i = 4'(dr);
      #1;
      expect_src(st, ak, av, eak, eav, na);
      expect_src(st, bk, bv, ebk, ebv, nb);
      chk(tag, "src_a_kind", int'(src_a_kind_o), eak);
      chk(tag, "src_a_val",  int'(src_a_val_o),  eav);
      chk(tag, "src_b_kind", int'(src_b_kind_o), ebk);
      chk(tag, "src_b_val",  int'(src_b_val_o),  ebv);
      if (st) for (int i = 0; i < NR; i++) begin m_wv[i] = 0; m_rv[i] = 0; end
      if (v) begin
         if (na && !m_rv[av % NR]) begin m_rv[av % NR] = 1; m_ra[av % NR] = slot; end
         if (nb && !m_rv[bv % NR]) begin m_rv[bv % NR] = 1; m_ra[bv % NR] = slot; end
         if (de) begin m_wv[dr] = 1; m_wa[dr] = slot; end
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < NR; i++) begin m_wv[i] = 0; m_rv[i] = 0; m_wa[i] = 0; m_ra[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_state("R1");
      rst_n = 1'b1;
      // R2: new word together with a microoperation
      step("R2", 1, 1, 0, 0, 5, 1, 3, 1, 3);
      // R4: reg 3 forwarded from slot 0
      step("R4", 0, 1, 1, 1, 3, 0, 200, 1, 7);
      // R7: reads and writes reg 9; reads see it unwritten
      step("R7", 0, 1, 2, 1, 9, 1, 9, 1, 9);
      // R8: reg 3 rewritten by slot 3; reg 7 forwarded from slot 1
      step("R8", 0, 1, 3, 1, 7, 1, 9, 1, 3);
      // R10: invalid cycle with a would-be write
      step("R10", 0, 0, 2, 1, 12, 1, 13, 1, 12);
      // R3: slot and reserved kinds pass through
      step("R3", 0, 1, 0, 2, 3, 3, 171, 0, 0);
      // R5: first reader of reg 12 is slot 1, second reader slot 2 does not replace it
      step("R5", 0, 1, 1, 1, 12, 0, 1, 0, 0);
      step("R5", 0, 1, 2, 0, 7, 1, 12, 0, 0);
      step("R6", 0, 1, 2, 1, 3, 1, 12, 0, 0);
      // R2: strobe with microoperation naming registers the old word wrote
      step("R2", 1, 1, 0, 1, 3, 1, 7, 1, 7);
      step("R2", 0, 1, 1, 1, 7, 1, 3, 0, 0);
      step("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0);
      step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0);
      for (int n = 0; n < 400; n++) begin
         int ak = $urandom_range(0, 3);
         int bk = $urandom_range(0, 3);
         int av = (ak == 1) ? $urandom_range(0, 5) : $urandom_range(0, 255);
         int bv = (bk == 1) ? $urandom_range(0, 5) : $urandom_range(0, 255);
         if (ak == 1 && $urandom_range(0, 7) == 0) av = $urandom_range(0, NR - 1);
         step("R9", ($urandom_range(0, 5) == 0), ($urandom_range(0, 4) != 0),
              $urandom_range(0, 3), ak, av, bk, bv, $urandom_range(0, 1),
              $urandom_range(0, 5));
      end
      step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0);
      summary();
      $finish;
   end
endmodule